// File: doc/BRIEF.md
# Position Sentence Framer

This block sits behind a serial receiver and watches a stream of 8-bit characters, each qualified by a valid strobe. It looks for the start of a position sentence, which is a dollar sign followed by the letters `G` and `P`. Once it has that prefix, it passes the body characters downstream one at a time with a write strobe and a running count. The body ends at a carriage return that is immediately followed by a line feed. When that happens the block raises a one-cycle completion pulse and presents the final body length on its own output.

Any break in the prefix sends the machine back to waiting for a new dollar sign. A carriage return followed by anything other than a line feed throws the sentence away. A body longer than the configured limit is cut off with an overflow pulse. If the state register ever holds an encoding the machine does not use, the block flags an error and returns to idle. Checksums and field parsing belong to blocks further downstream.

Top module: `nmea_framer`

## Requirements
- R1: After reset, every output (`bodyValid`, `bodyByte`, `bodyLen`, `msgDone`, `msgLen`, `overflowPulse`, `stateError`) is zero.
- R2: While idle, every character other than `$` (0x24) is ignored and no body byte is produced.
- R3: After `$`, the next accepted character must be `G` (0x47), and after that one it must be `P` (0x50). Any other character returns the machine to idle, and that character is not itself taken as a new `$` start.
- R4: A character presented while `inValid` is low has no effect on the machine or on any output.
- R5: Every accepted body character other than CR (0x0D) appears on `bodyByte` with `bodyValid` high for exactly one cycle, in the cycle after the one in which it was accepted.
- R6: The length is cleared when `P` is accepted. On each `bodyValid` cycle, `bodyLen` equals the number of body bytes produced so far in the current sentence, so the first body byte carries 1.
- R7: A CR followed directly by an LF (0x0A) produces a one-cycle `msgDone` pulse in the cycle after the LF, with `msgLen` equal to the body length. An empty body gives 0.
- R8: A CR followed by any accepted character other than LF discards the sentence: no `msgDone` is raised and the machine returns to idle.
- R9: A body may hold at most `MAX_LEN` bytes. The next non-CR body character raises `overflowPulse` for one cycle, is not emitted, and returns the machine to idle.
- R10: An unused state encoding raises `stateError` for one cycle and forces the machine to idle. In legal operation `stateError` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Character strobe |
| inChar | input | 8 | Incoming character |
| bodyValid | output | 1 | Body byte write strobe |
| bodyByte | output | 8 | Body byte |
| bodyLen | output | $clog2(MAX_LEN+1) | Running body length |
| msgDone | output | 1 | One-cycle sentence-complete pulse |
| msgLen | output | $clog2(MAX_LEN+1) | Final body length, valid with msgDone |
| overflowPulse | output | 1 | Body exceeded MAX_LEN |
| stateError | output | 1 | Illegal state encoding seen |

## Verification
The bench builds the framer with a limit of six. It sweeps the body length from zero up to one past the limit, checking each payload byte, the running length and the final length. A counter that was off by one would show up either at the empty sentence or at the byte where the limit is reached. The bench also sends broken prefixes such as `$$GP` and `$G$GP`; a machine that re-examined the mismatching character would wrongly accept them. It sends a CR followed by a stray character, which a sloppy terminator check would accept. Finally, it places junk characters with the strobe low both inside and between sentences; an ungated machine would pick these up as starts or as body bytes.

// File: rtl/nmea_framer_pkg.sv
package nmea_framer_pkg;

  localparam logic [7:0] CH_DOLLAR = 8'h24;
  localparam logic [7:0] CH_G      = 8'h47;
  localparam logic [7:0] CH_P      = 8'h50;
  localparam logic [7:0] CH_CR     = 8'h0D;
  localparam logic [7:0] CH_LF     = 8'h0A;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WANTG = 3'd1,
    ST_WANTP = 3'd2,
    ST_BODY  = 3'd3,
    ST_WANTLF = 3'd4
  } framerState_t;

  typedef struct packed {
    logic clearLen;
    logic emitByte;
    logic finish;
    logic overflow;
    logic error;
  } ctlStrobe_t;

endpackage

// File: rtl/sentence_ctrl.sv
module sentence_ctrl
  import nmea_framer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inChar,
  input  logic       lenAtMax,
  output ctlStrobe_t strobe
);

  framerState_t state;
  framerState_t stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (inValid && inChar == CH_DOLLAR) stateNext = ST_WANTG;
      end
      ST_WANTG: begin
        if (inValid) stateNext = (inChar == CH_G) ? ST_WANTP : ST_IDLE;
      end
      ST_WANTP: begin
        if (inValid) begin
          if (inChar == CH_P) begin
            stateNext       = ST_BODY;
            strobe.clearLen = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_BODY: begin
        if (inValid) begin
          if (inChar == CH_CR) begin
            stateNext = ST_WANTLF;
          end else if (lenAtMax) begin
            strobe.overflow = 1'b1;
            stateNext       = ST_IDLE;
          end else begin
            strobe.emitByte = 1'b1;
          end
        end
      end
      ST_WANTLF: begin
        if (inValid) begin
          strobe.finish = (inChar == CH_LF);
          stateNext     = ST_IDLE;
        end
      end
      default: begin
        strobe.error = 1'b1;
        stateNext    = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R4: the machine only moves on strobed characters
  a_r4_hold_without_valid: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && state inside {ST_IDLE, ST_WANTG, ST_WANTP, ST_BODY, ST_WANTLF})
      |=> $stable(state));

  // R5: a body byte is only written for a strobed character
  a_r5_emit_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitByte |-> inValid);

  // R3: the body is only entered straight after the P of the prefix
  a_r3_body_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BODY && $past(state) != ST_BODY && $past(state) != ST_IDLE)
      |-> $past(state) == ST_WANTP && $past(inChar) == CH_P);

  // R10: legal encodings only
  a_r10_legal_state: assert property (@(posedge clk) disable iff (!rstN)
    $countones({state == ST_IDLE, state == ST_WANTG, state == ST_WANTP,
                state == ST_BODY, state == ST_WANTLF}) == 1);

endmodule

// File: rtl/sentence_dpath.sv
module sentence_dpath
  import nmea_framer_pkg::*;
#(
  parameter int MAX_LEN = 80,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inChar,
  input  ctlStrobe_t       strobe,
  output logic             lenAtMax,
  output logic             bodyValid,
  output logic [7:0]       bodyByte,
  output logic [LEN_W-1:0] bodyLen,
  output logic             msgDone,
  output logic [LEN_W-1:0] msgLen,
  output logic             overflowPulse,
  output logic             stateError
);

  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);

  logic [LEN_W-1:0] lenCnt;

  assign lenAtMax = (lenCnt == LEN_LIMIT);
  assign bodyLen  = lenCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenCnt <= '0;
    end else if (strobe.clearLen) begin
      lenCnt <= '0;
    end else if (strobe.emitByte) begin
      lenCnt <= lenCnt + LEN_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bodyValid     <= 1'b0;
      bodyByte      <= '0;
      msgDone       <= 1'b0;
      msgLen        <= '0;
      overflowPulse <= 1'b0;
      stateError    <= 1'b0;
    end else begin
      bodyValid     <= strobe.emitByte;
      msgDone       <= strobe.finish;
      overflowPulse <= strobe.overflow;
      stateError    <= strobe.error;
      if (strobe.emitByte) bodyByte <= inChar;
      if (strobe.finish)   msgLen   <= lenCnt;
    end
  end

  // R7: completion lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |=> !msgDone);

  // R9: the running length never passes the limit
  a_r9_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    lenCnt <= LEN_LIMIT);

  // R6: each written byte steps the count by one or starts it at one
  a_r6_len_step: assert property (@(posedge clk) disable iff (!rstN)
    bodyValid |-> (lenCnt == LEN_ONE || lenCnt == $past(lenCnt) + LEN_ONE));

  // R9: an overflow never coincides with a write or a completion
  a_r9_overflow_alone: assert property (@(posedge clk) disable iff (!rstN)
    overflowPulse |-> (!bodyValid && !msgDone));

  // R10: no illegal state is ever reported in normal use
  a_r10_no_error: assert property (@(posedge clk) disable iff (!rstN)
    !stateError);

endmodule

// File: rtl/nmea_framer.sv
module nmea_framer
  import nmea_framer_pkg::*;
#(
  parameter int MAX_LEN = 80,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inChar,
  output logic             bodyValid,
  output logic [7:0]       bodyByte,
  output logic [LEN_W-1:0] bodyLen,
  output logic             msgDone,
  output logic [LEN_W-1:0] msgLen,
  output logic             overflowPulse,
  output logic             stateError
);

  ctlStrobe_t strobe;
  logic       lenAtMax;

  sentence_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inChar   (inChar),
    .lenAtMax (lenAtMax),
    .strobe   (strobe)
  );

  sentence_dpath #(.MAX_LEN(MAX_LEN)) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .inChar        (inChar),
    .strobe        (strobe),
    .lenAtMax      (lenAtMax),
    .bodyValid     (bodyValid),
    .bodyByte      (bodyByte),
    .bodyLen       (bodyLen),
    .msgDone       (msgDone),
    .msgLen        (msgLen),
    .overflowPulse (overflowPulse),
    .stateError    (stateError)
  );

  // R8: completion only follows a line feed
  a_r8_done_after_lf: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |-> $past(inValid) && $past(inChar) == CH_LF);

endmodule

// File: tb/nmea_framer_tb_top.sv
module nmea_framer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 6;
  localparam int LW = $clog2(MAXL + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [7:0]    inChar = 8'h00;
  logic          bodyValid;
  logic [7:0]    bodyByte;
  logic [LW-1:0] bodyLen;
  logic          msgDone;
  logic [LW-1:0] msgLen;
  logic          overflowPulse;
  logic          stateError;

  nmea_framer #(.MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChar(inChar),
    .bodyValid(bodyValid), .bodyByte(bodyByte), .bodyLen(bodyLen),
    .msgDone(msgDone), .msgLen(msgLen), .overflowPulse(overflowPulse),
    .stateError(stateError)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int nBytes, doneCnt, lastLen, ovfCnt, errCnt, lenBad, curCount;
  logic [7:0] capBuf [0:31];
  logic [7:0] gapChar = 8'h24;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearCounts();
    nBytes = 0; doneCnt = 0; lastLen = -1; ovfCnt = 0; errCnt = 0;
    lenBad = 0; curCount = 0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (bodyValid) begin
        curCount++;
        if (nBytes < 32) capBuf[nBytes] = bodyByte;
        nBytes++;
        if (int'(bodyLen) != curCount) lenBad++;
      end
      if (msgDone) begin
        doneCnt++;
        lastLen = int'(msgLen);
      end
      if (overflowPulse) ovfCnt++;
      if (stateError) errCnt++;
    end
  end

  task automatic sendChar(input logic [7:0] c, input bit gap);
    @(negedge clk);
    inValid = 1'b1;
    inChar  = c;
    @(negedge clk);
    inValid = 1'b0;
    inChar  = gap ? gapChar : 8'h00;
    if (gap) @(negedge clk);
  endtask

  task automatic sendStr(input string s, input bit gap);
    for (int i = 0; i < s.len(); i++) sendChar(s[i], gap);
  endtask

  task automatic settle();
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendMsg(input int len, input bit gap);
    sendStr("$GP", gap);
    curCount = 0;
    for (int i = 0; i < len; i++) sendChar(8'h61 + 8'(i), gap);
    sendChar(8'h0D, gap);
    sendChar(8'h0A, gap);
  endtask

  function automatic int byteMismatch(input int n);
    int bad = 0;
    for (int i = 0; i < n && i < 32; i++)
      if (capBuf[i] != 8'h61 + 8'(i)) bad++;
    return bad;
  endfunction

  initial begin
    #(CLK_PERIOD * 40000);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearCounts();
    inValid = 1'b1;
    inChar  = 8'h24;
    repeat (4) @(negedge clk);
    // R1: outputs held at zero across reset
    check("R1 bodyValid", int'(bodyValid), 0);
    check("R1 bodyByte", int'(bodyByte), 0);
    check("R1 bodyLen", int'(bodyLen), 0);
    check("R1 msgDone", int'(msgDone), 0);
    check("R1 msgLen", int'(msgLen), 0);
    check("R1 overflowPulse", int'(overflowPulse), 0);
    check("R1 stateError", int'(stateError), 0);
    inValid = 1'b0;
    rstN = 1'b1;
    settle();

    // R4: a full sentence presented with the strobe low does nothing
    clearCounts();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      case (i)
        0: inChar = 8'h24; 1: inChar = 8'h47; 2: inChar = 8'h50;
        3: inChar = 8'h61; 4: inChar = 8'h62; 5: inChar = 8'h0D;
        6: inChar = 8'h0A; default: inChar = 8'h00;
      endcase
    end
    settle();
    check("R4 bytes with strobe low", nBytes, 0);
    check("R4 done with strobe low", doneCnt, 0);

    // R5 R6 R7 R9: sweep of body lengths, with and without gaps
    for (int g = 0; g < 2; g++) begin
      for (int len = 0; len <= MAXL + 1; len++) begin
        clearCounts();
        gapChar = (len % 2 == 0) ? 8'h24 : 8'h0D;
        sendMsg(len, g[0]);
        settle();
        if (len <= MAXL) begin
          check("R5 byte count", nBytes, len);
          check("R5 byte values", byteMismatch(len), 0);
          check("R6 running length", lenBad, 0);
          check("R7 done count", doneCnt, 1);
          check("R7 final length", lastLen, len);
          check("R9 no overflow", ovfCnt, 0);
        end else begin
          check("R9 bytes kept", nBytes, MAXL);
          check("R9 overflow pulses", ovfCnt, 1);
          check("R9 no done", doneCnt, 0);
          check("R9 byte values", byteMismatch(MAXL), 0);
        end
      end
    end

    // R2: junk before the dollar is ignored
    clearCounts();
    sendStr("xGPq", 1'b0);
    sendChar(8'h0D, 1'b0);
    sendChar(8'h0A, 1'b0);
    settle();
    check("R2 junk bytes", nBytes, 0);
    check("R2 junk done", doneCnt, 0);
    clearCounts();
    sendStr("zz", 1'b0);
    sendMsg(3, 1'b0);
    settle();
    check("R2 message after junk", doneCnt, 1);
    check("R2 length after junk", lastLen, 3);

    // R3: broken prefixes, with the mismatching character not restarting
    for (int k = 0; k < 4; k++) begin
      clearCounts();
      case (k)
        0: sendStr("$XPab", 1'b0);
        1: sendStr("$GXab", 1'b0);
        2: sendStr("$$GPab", 1'b0);
        default: sendStr("$G$GPab", 1'b0);
      endcase
      sendChar(8'h0D, 1'b0);
      sendChar(8'h0A, 1'b0);
      settle();
      check("R3 broken prefix bytes", nBytes, 0);
      check("R3 broken prefix done", doneCnt, 0);
    end

    // R8: CR followed by a stray character discards
    clearCounts();
    sendStr("$GPab", 1'b0);
    sendChar(8'h0D, 1'b0);
    sendChar(8'h58, 1'b0);
    sendChar(8'h0A, 1'b0);
    settle();
    check("R8 bytes before discard", nBytes, 2);
    check("R8 no done after stray", doneCnt, 0);
    clearCounts();
    sendStr("$GPab", 1'b0);
    sendChar(8'h0D, 1'b0);
    sendChar(8'h0D, 1'b0);
    sendChar(8'h0A, 1'b0);
    settle();
    check("R8 no done after double CR", doneCnt, 0);

    // R7: two sentences back to back
    clearCounts();
    sendMsg(2, 1'b0);
    sendMsg(4, 1'b0);
    settle();
    check("R7 back to back done", doneCnt, 2);
    check("R7 back to back last length", lastLen, 4);
    check("R6 back to back running length", lenBad, 0);

    // R10: no error pulse seen in any of the above
    check("R10 stateError count", errCnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule